// File: doc/BRIEF.md
# PWM Comparison Event Generator

This block produces single-clock comparison events that line up with the cycle of a reference PWM counter. It holds up to eight independent comparison units. Each unit watches the running channel counter and fires when that counter reaches its compare value. The firing is further limited to one chosen period out of a repeating group of reference periods. A small period counter, advanced by the reference period-end strobe, selects that period: it counts up to a programmed limit and the unit may fire only while it equals a programmed trigger value.

Software programs a unit by writing a word to a write-only staging register, with a unit index to pick the target. The staged word holds the enable, trigger, period limit and update interval. The active settings and the compare value change together, and only when a second per-unit counter reaches the end of its update interval. An event therefore never comes from a half-applied configuration.

Top module: `cmpev_gen`

## Requirements
- R1: After reset, all staged and active settings, both counters of every unit and `match_o` are zero, so no unit is enabled.
- R2: The staging word uses bit 0 as enable, bits 7:4 as trigger value, bits 11:8 as period limit and bits 19:16 as update interval. All other bits are ignored.
- R3: A write to the staging register changes only the staged values. The active settings, and therefore the events, stay unchanged until the next commit.
- R4: The update counter advances on each period-end strobe and returns to 0 on a strobe that finds it at or above the active update interval. That strobe commits the staged settings and samples the unit's compare value input, so a commit happens once every interval+1 periods.
- R5: The period counter changes only on a period-end strobe. On such a strobe it returns to 0 if it is at or above the active period limit, and otherwise it increments.
- R6: A unit whose active enable is 0 never produces an event.
- R7: A unit's event condition holds in a cycle when the unit is enabled, its period counter equals the active trigger value, and `chan_cnt_i` equals the active compare value.
- R8: `match_o[i]` is high for exactly the one clock after the first cycle of a run of consecutive cycles in which the event condition holds.
- R9: When several writes reach one unit between commits, the last write is the one that gets committed.
- R10: A write reaches only the unit selected by `upd_idx_i`. The other units keep their staged values.
- R11: When a write and a commit fall in the same cycle, the commit takes the staged values from before that write. The new write stays pending for the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_end_i | input | 1 | One-cycle strobe at the end of each reference period |
| chan_cnt_i | input | CNT_W | Current channel counter value |
| cmp_val_i | input | NUM_CMP*CNT_W | Compare value per unit; unit i uses bits [i*CNT_W +: CNT_W] |
| upd_wr_i | input | 1 | Write strobe for the staging register |
| upd_idx_i | input | 3 | Index of the unit being written |
| upd_data_i | input | 32 | Staging word (layout in R2) |
| match_o | output | NUM_CMP | Per-unit comparison event pulse |

## Verification
The assertions check several properties on every cycle:
- No event comes from a disabled unit.
- An event always follows a cycle in which the period counter matched the trigger and the channel counter matched the compare value.
- An event never lasts two clocks.
- The period counter never moves without a strobe.
- The active settings never change outside a commit strobe.

The bench scenarios are needed for the rest:
- field decoding and the ignored bits;
- that the last staged write wins;
- the ordering when a write and a commit share a cycle;
- per-unit selection;
- the exact period in which an event appears.

A cycle-accurate model in the bench covers these under directed sequences and random traffic.

// File: rtl/cmpev_pkg.sv
package cmpev_pkg;
   localparam int MAX_UNITS = 8;
   localparam int IDX_W     = 3;
   localparam int WORD_W    = 32;
   localparam int FLD_MAX   = 4;
   localparam int EN_BIT    = 0;
   localparam int TRIG_LSB  = 4;
   localparam int PER_LSB   = 8;
   localparam int INTV_LSB  = 16;
endpackage

// File: rtl/cmpev_stage.sv
module cmpev_stage
   import cmpev_pkg::*;
#(
   parameter int FLD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              en_o,
   output logic [FLD_W-1:0]  trig_o,
   output logic [FLD_W-1:0]  per_o,
   output logic [FLD_W-1:0]  intv_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         trig_o <= '0;
         per_o  <= '0;
         intv_o <= '0;
      end else if (wr_i) begin
         en_o   <= data_i[EN_BIT];
         trig_o <= data_i[TRIG_LSB +: FLD_W];
         per_o  <= data_i[PER_LSB  +: FLD_W];
         intv_o <= data_i[INTV_LSB +: FLD_W];
      end
   end
endmodule

// File: rtl/cmpev_sched.sv
module cmpev_sched #(
   parameter int FLD_W = 4,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_end_i,
   input  logic             stg_en_i,
   input  logic [FLD_W-1:0] stg_trig_i,
   input  logic [FLD_W-1:0] stg_per_i,
   input  logic [FLD_W-1:0] stg_intv_i,
   input  logic [CNT_W-1:0] cval_i,
   output logic             act_en_o,
   output logic [FLD_W-1:0] act_trig_o,
   output logic [FLD_W-1:0] act_per_o,
   output logic [FLD_W-1:0] act_intv_o,
   output logic [CNT_W-1:0] act_cval_o,
   output logic [FLD_W-1:0] per_cnt_o,
   output logic [FLD_W-1:0] upd_cnt_o
);
   logic upd_wrap;
   logic per_wrap;
   logic commit;

   assign upd_wrap = (upd_cnt_o >= act_intv_o);
   assign per_wrap = (per_cnt_o >= act_per_o);
   assign commit   = period_end_i & upd_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt_o <= '0;
         upd_cnt_o <= '0;
      end else if (period_end_i) begin
         per_cnt_o <= per_wrap ? '0 : per_cnt_o + 1'b1;
         upd_cnt_o <= upd_wrap ? '0 : upd_cnt_o + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en_o   <= 1'b0;
         act_trig_o <= '0;
         act_per_o  <= '0;
         act_intv_o <= '0;
         act_cval_o <= '0;
      end else if (commit) begin
         act_en_o   <= stg_en_i;
         act_trig_o <= stg_trig_i;
         act_per_o  <= stg_per_i;
         act_intv_o <= stg_intv_i;
         act_cval_o <= cval_i;
      end
   end
endmodule

// File: rtl/cmpev_hit.sv
module cmpev_hit #(
   parameter int FLD_W     = 4,
   parameter int CNT_W     = 16,
   parameter bit MATCH_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [FLD_W-1:0] per_cnt_i,
   input  logic [FLD_W-1:0] trig_i,
   input  logic [CNT_W-1:0] chan_i,
   input  logic [CNT_W-1:0] cval_i,
   output logic             match_o
);
   logic hit;
   logic hit_q;

   assign hit = en_i && (per_cnt_i == trig_i) && (chan_i == cval_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= hit;
   end

   generate
      if (MATCH_REG) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= hit & ~hit_q;
         end
         assign match_o = pulse_q;
      end else begin : g_comb
         assign match_o = hit & ~hit_q;
      end
   endgenerate
endmodule

// File: rtl/cmpev_gen.sv
module cmpev_gen
   import cmpev_pkg::*;
#(
   parameter int NUM_CMP   = 8,
   parameter int CNT_W     = 16,
   parameter int FLD_W     = 4,
   parameter bit MATCH_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     period_end_i,
   input  logic [CNT_W-1:0]         chan_cnt_i,
   input  logic [NUM_CMP*CNT_W-1:0] cmp_val_i,
   input  logic                     upd_wr_i,
   input  logic [2:0]               upd_idx_i,
   input  logic [31:0]              upd_data_i,
   output logic [NUM_CMP-1:0]       match_o
);
   localparam int FLD_BITS = NUM_CMP * FLD_W;

   generate
      if (NUM_CMP < 1 || NUM_CMP > MAX_UNITS) begin : g_bad_units
         $error("cmpev_gen: NUM_CMP out of range");
      end
      if (FLD_W < 1 || FLD_W > FLD_MAX) begin : g_bad_fld
         $error("cmpev_gen: FLD_W out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cmpev_gen: CNT_W out of range");
      end
   endgenerate

   logic [NUM_CMP-1:0]       act_en_w;
   logic [FLD_BITS-1:0]      act_trig_w;
   logic [FLD_BITS-1:0]      act_per_w;
   logic [FLD_BITS-1:0]      act_intv_w;
   logic [NUM_CMP*CNT_W-1:0] act_cval_w;
   logic [FLD_BITS-1:0]      per_cnt_w;
   logic [FLD_BITS-1:0]      upd_cnt_w;

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_unit
         logic             sel;
         logic             s_en;
         logic [FLD_W-1:0] s_trig;
         logic [FLD_W-1:0] s_per;
         logic [FLD_W-1:0] s_intv;

         assign sel = upd_wr_i && (upd_idx_i == IDX_W'(i));

         cmpev_stage #(.FLD_W(FLD_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (sel),
            .data_i (upd_data_i),
            .en_o   (s_en),
            .trig_o (s_trig),
            .per_o  (s_per),
            .intv_o (s_intv)
         );

         cmpev_sched #(.FLD_W(FLD_W), .CNT_W(CNT_W)) u_sched (
            .clk          (clk),
            .rst_n        (rst_n),
            .period_end_i (period_end_i),
            .stg_en_i     (s_en),
            .stg_trig_i   (s_trig),
            .stg_per_i    (s_per),
            .stg_intv_i   (s_intv),
            .cval_i       (cmp_val_i[i*CNT_W +: CNT_W]),
            .act_en_o     (act_en_w[i]),
            .act_trig_o   (act_trig_w[i*FLD_W +: FLD_W]),
            .act_per_o    (act_per_w[i*FLD_W +: FLD_W]),
            .act_intv_o   (act_intv_w[i*FLD_W +: FLD_W]),
            .act_cval_o   (act_cval_w[i*CNT_W +: CNT_W]),
            .per_cnt_o    (per_cnt_w[i*FLD_W +: FLD_W]),
            .upd_cnt_o    (upd_cnt_w[i*FLD_W +: FLD_W])
         );

         cmpev_hit #(.FLD_W(FLD_W), .CNT_W(CNT_W), .MATCH_REG(MATCH_REG)) u_hit (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (act_en_w[i]),
            .per_cnt_i (per_cnt_w[i*FLD_W +: FLD_W]),
            .trig_i    (act_trig_w[i*FLD_W +: FLD_W]),
            .chan_i    (chan_cnt_i),
            .cval_i    (act_cval_w[i*CNT_W +: CNT_W]),
            .match_o   (match_o[i])
         );
      end
   endgenerate
endmodule

// File: rtl/cmpev_chk.sv
module cmpev_chk #(
   parameter int NUM_CMP   = 8,
   parameter int CNT_W     = 16,
   parameter int FLD_W     = 4,
   parameter bit MATCH_REG = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     period_end_i,
   input logic [CNT_W-1:0]         chan_cnt_i,
   input logic [NUM_CMP-1:0]       match_o,
   input logic [NUM_CMP-1:0]       act_en,
   input logic [NUM_CMP*FLD_W-1:0] act_trig,
   input logic [NUM_CMP*FLD_W-1:0] act_per,
   input logic [NUM_CMP*FLD_W-1:0] act_intv,
   input logic [NUM_CMP*CNT_W-1:0] act_cval,
   input logic [NUM_CMP*FLD_W-1:0] per_cnt,
   input logic [NUM_CMP*FLD_W-1:0] upd_cnt
);
   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
         a_r5_count_on_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
            !period_end_i |=> $stable(per_cnt[i*FLD_W +: FLD_W]));

         a_r4_commit_on_wrap_only: assert property (@(posedge clk) disable iff (!rst_n)
            !(period_end_i && (upd_cnt[i*FLD_W +: FLD_W] >= act_intv[i*FLD_W +: FLD_W]))
            |=> $stable({act_en[i], act_trig[i*FLD_W +: FLD_W], act_per[i*FLD_W +: FLD_W],
                         act_intv[i*FLD_W +: FLD_W], act_cval[i*CNT_W +: CNT_W]}));

         if (MATCH_REG) begin : g_regchk
            a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
               match_o[i] |-> $past(act_en[i]));

            a_r7_event_condition: assert property (@(posedge clk) disable iff (!rst_n)
               match_o[i] |-> $past((per_cnt[i*FLD_W +: FLD_W] == act_trig[i*FLD_W +: FLD_W])
                                    && (chan_cnt_i == act_cval[i*CNT_W +: CNT_W])));

            a_r8_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
               match_o[i] |=> !match_o[i]);
         end
      end
   endgenerate
endmodule

bind cmpev_gen cmpev_chk #(
   .NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .FLD_W(FLD_W), .MATCH_REG(MATCH_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .period_end_i (period_end_i),
   .chan_cnt_i   (chan_cnt_i),
   .match_o      (match_o),
   .act_en       (act_en_w),
   .act_trig     (act_trig_w),
   .act_per      (act_per_w),
   .act_intv     (act_intv_w),
   .act_cval     (act_cval_w),
   .per_cnt      (per_cnt_w),
   .upd_cnt      (upd_cnt_w)
);

// File: tb/tb_cmpev_gen.sv
module tb_cmpev_gen;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int CW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            period_end_i = 1'b0;
   logic [CW-1:0]   chan_cnt_i = '0;
   logic [N*CW-1:0] cmp_val_i;
   logic            upd_wr_i = 1'b0;
   logic [2:0]      upd_idx_i = '0;
   logic [31:0]     upd_data_i = '0;
   logic [N-1:0]    match_o;

   logic [CW-1:0] cv [N];
   always_comb for (int i = 0; i < N; i++) cmp_val_i[i*CW +: CW] = cv[i];

   cmpev_gen dut (
      .clk(clk), .rst_n(rst_n), .period_end_i(period_end_i), .chan_cnt_i(chan_cnt_i),
      .cmp_val_i(cmp_val_i), .upd_wr_i(upd_wr_i), .upd_idx_i(upd_idx_i),
      .upd_data_i(upd_data_i), .match_o(match_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   bit       s_en [N];
   bit [3:0] s_trig [N], s_per [N], s_intv [N];
   bit       a_en [N];
   bit [3:0] a_trig [N], a_per [N], a_intv [N];
   bit [CW-1:0] a_cval [N];
   bit [3:0] m_per [N], m_upd [N];
   bit       m_hitq [N];
   bit [N-1:0] m_match;

   function automatic bit [N-1:0] step_model(input bit pe, input bit [CW-1:0] cc,
                                            input bit wr, input bit [2:0] idx,
                                            input bit [31:0] d);
      bit [N-1:0] nm;
      nm = '0;
      for (int i = 0; i < N; i++) begin
         bit hit, uw;
         hit = a_en[i] && (m_per[i] == a_trig[i]) && (cc == a_cval[i]);
         nm[i] = hit && !m_hitq[i];
         m_hitq[i] = hit;
         uw = (m_upd[i] >= a_intv[i]);
         if (pe) begin
            m_per[i] = (m_per[i] >= a_per[i]) ? 4'd0 : m_per[i] + 4'd1;
            m_upd[i] = uw ? 4'd0 : m_upd[i] + 4'd1;
            if (uw) begin
               a_en[i] = s_en[i]; a_trig[i] = s_trig[i];
               a_per[i] = s_per[i]; a_intv[i] = s_intv[i];
               a_cval[i] = cv[i];
            end
         end
         if (wr && idx == 3'(i)) begin
            s_en[i] = d[0]; s_trig[i] = d[7:4]; s_per[i] = d[11:8]; s_intv[i] = d[19:16];
         end
      end
      return nm;
   endfunction

   task automatic check(input bit [N-1:0] exp, input string tag);
      n_chk++;
      if (match_o !== exp) begin
         n_bad++;
         $display("FAIL %s: match_o actual=%b expected=%b at %0t", tag, match_o, exp, $time);
      end
   endtask

   task automatic tick(input bit pe, input bit [CW-1:0] cc, input bit wr,
                       input bit [2:0] idx, input bit [31:0] d, input string tag);
      period_end_i = pe; chan_cnt_i = cc; upd_wr_i = wr; upd_idx_i = idx; upd_data_i = d;
      m_match = step_model(pe, cc, wr, idx, d);
      @(posedge clk);
      @(negedge clk);
      check(m_match, tag);
   endtask

   task automatic periods(input int n, input string tag);
      for (int p = 0; p < n; p++)
         for (int c = 0; c < 8; c++)
            tick(c == 7, CW'(c), 1'b0, 3'd0, 32'd0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit [31:0] seed;
      int cc;
      seed = 32'd12345;
      void'($urandom(seed));
      for (int i = 0; i < N; i++) begin
         cv[i] = CW'(i);
         s_en[i] = 0; s_trig[i] = 0; s_per[i] = 0; s_intv[i] = 0;
         a_en[i] = 0; a_trig[i] = 0; a_per[i] = 0; a_intv[i] = 0; a_cval[i] = 0;
         m_per[i] = 0; m_upd[i] = 0; m_hitq[i] = 0;
      end
      repeat (3) @(negedge clk);
      check('0, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check('0, "R1 after release");
      periods(2, "R1 idle no events");

      // R2 / R10: unit 2 only, with junk in ignored bits
      tick(0, 0, 1, 3'd2, 32'hABC0_F32F, "R2 R10 write");
      periods(6, "R2 R10 decoded fields");

      // R9: two writes to unit 4; second one disables
      tick(0, 1, 1, 3'd4, 32'h0000_0101, "R9 first write");
      tick(0, 2, 1, 3'd4, 32'h0000_0100, "R9 second write");
      periods(4, "R9 last write wins");

      // R3: long update interval on unit 5, staged write stays pending
      tick(0, 0, 1, 3'd5, 32'h0003_0001, "R3 write");
      periods(2, "R3 interval committed");
      tick(0, 0, 1, 3'd5, 32'h0000_0000, "R3 staged disable");
      periods(3, "R3 active unchanged before commit");
      periods(3, "R3 after commit");

      // R11: write coinciding with commit strobe on unit 6
      for (int c = 0; c < 7; c++) tick(0, CW'(c), 0, 0, 0, "R11 lead");
      tick(1, 7, 1, 3'd6, 32'h0000_0061, "R11 same-cycle write");
      periods(1, "R11 old value committed");
      periods(2, "R11 new value next commit");

      // R4 R5: interval and period mixes, random traffic
      cc = 0;
      for (int k = 0; k < 4000; k++) begin
         bit wr;
         bit [31:0] d;
         if (($urandom % 97) == 0) cv[$urandom % N] = CW'($urandom % 8);
         wr = (($urandom % 25) == 0);
         d  = $urandom & 32'hFFF3_F3F1;
         tick(cc == 7, CW'(cc), wr, 3'($urandom % N), d, "R2 R3 R4 R5 R6 R7 R8 random");
         cc = (cc == 7) ? 0 : cc + 1;
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule